// File: doc/BRIEF.md
# Command-Stream Packet Parser

This block sits on a stream of 32-bit command words and splits it into packets. A valid/ready handshake delivers the words. The top two bits of each header word give the packet kind, and the parser then takes exactly as many payload words as that header announces before it treats the next word as a header again. The block only parses and forwards. It does not execute commands and it has no access to memory.

There are two kinds of register-write packet: a run of writes, and a fixed pair of writes. Both become a series of register-index/data beats on a write port. A run either steps the register index by one per word or stays on a single register, and a bit in the header chooses which. A no-op header is consumed and dropped. A command header becomes a start beat on a command port that carries the opcode, the payload length and the predicate bit. Each payload word then follows on the same port, tagged with its position. One command form, a presentation request, must begin with a fixed signature word, and the block flags it when that word does not match.

Top module: `cmdstream_parser`

## Requirements
- R1: While reset is held and right after it, `rw_valid`, `cmd_valid`, `pkt_done` and `sig_err` are 0, and `in_ready` is 1 once reset is released with both output ports empty.
- R2: Header bits 31:30 select the packet kind: 0 is a register run, 1 is a register pair, 2 is a no-op and 3 is a command. A word is a header only when no packet is in progress.
- R3: A run header carries the first register index in bits 14:0, a hold flag in bit 15 and a length field in bits 29:16. It is followed by field+1 data words (1 to 16384). With hold clear, each word writes index+k modulo 2^15. With hold set, every word writes the first index.
- R4: A pair header carries a first index in bits 10:0 and a second index in bits 21:11. The next two words are written to the first index and then to the second index, with each index zero-extended to 15 bits.
- R5: A no-op header produces no write beat and no command beat, and the next word is decoded as a header.
- R6: A command header produces one beat with `cmd_start`=1, `cmd_opcode` = bits 14:8, `cmd_count` = bits 29:16 plus one, `cmd_pred` = bit 0, `cmd_pos`=0 and `cmd_data` equal to the header word.
- R7: Each of the `cmd_count` payload words of a command produces one beat with `cmd_start`=0, the opcode, count and predicate fields at 0, `cmd_pos` running from 0 upward and `cmd_data` equal to the word.
- R8: For a command with opcode 0x64 and a count of 4, `sig_err` pulses in the cycle its first payload word is accepted if that word differs from 0x584E4558. For any other opcode or count, and for a matching word, it stays 0.
- R9: `pkt_done` is 1 exactly in the cycle in which the last word of a packet is accepted: the header of a no-op, otherwise the final payload word.
- R10: A beat stalled by a low ready stays valid and unchanged. `in_ready` is 0 while either output port holds a stalled beat. No word is lost or emitted twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_word | input | 32 | Command stream word |
| in_ready | output | 1 | Parser accepts the word this cycle |
| rw_valid | output | 1 | Register-write beat valid |
| rw_ready | input | 1 | Register-write port accepts the beat |
| rw_index | output | 15 | Register index of the write |
| rw_data | output | 32 | Data of the write |
| cmd_valid | output | 1 | Command beat valid |
| cmd_ready | input | 1 | Command port accepts the beat |
| cmd_start | output | 1 | Beat is a command start (header) |
| cmd_opcode | output | 7 | Command opcode (start beats) |
| cmd_count | output | 15 | Payload word count (start beats) |
| cmd_pred | output | 1 | Predicate flag (start beats) |
| cmd_pos | output | 14 | Payload word position |
| cmd_data | output | 32 | Header or payload word |
| pkt_done | output | 1 | Final word of a packet accepted this cycle |
| sig_err | output | 1 | Presentation signature mismatch |

## Verification
The hardest case to reach from the ports is the run with the longest length field. It takes 16384 data words, and the length counter must land back on the header state after exactly the last one. The stimulus includes one such run among the short packets, so a header word that follows it is decoded correctly only if the count matched. Index wraparound at 0x7FFF is forced with a short run based at 0x7FFE. The signature check is hit with a matching word, a wrong word, the right opcode at a different length, and a different opcode. All of this runs under random valid and ready patterns, so stalls land on start beats, on payload beats and on header words alike.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 14;
  localparam int IDX_W  = 15;
  localparam int PAIR_W = 11;
  localparam int OPC_W  = 7;
  localparam int NUM_W  = CNT_W + 1;

  typedef enum logic [1:0] {
    PK_RUN  = 2'd0,
    PK_PAIR = 2'd1,
    PK_NOP  = 2'd2,
    PK_CMD  = 2'd3
  } pkind_e;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_RUN,
    ST_PR_A,
    ST_PR_B,
    ST_PAY
  } pstate_e;

  typedef struct packed {
    pkind_e              kind;
    logic [CNT_W-1:0]    len_m1;
    logic [IDX_W-1:0]    base;
    logic                hold;
    logic [PAIR_W-1:0]   idx_a;
    logic [PAIR_W-1:0]   idx_b;
    logic [OPC_W-1:0]    opc;
    logic                pred;
  } hdr_t;

endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);

  always_comb begin
    hdr.kind   = pkind_e'(word[31:30]);
    hdr.len_m1 = word[29:16];
    hdr.hold   = word[15];
    hdr.base   = word[14:0];
    hdr.idx_a  = word[10:0];
    hdr.idx_b  = word[21:11];
    hdr.opc    = word[14:8];
    hdr.pred   = word[0];
  end

endmodule

// File: rtl/cmdp_out_slot.sv
module cmdp_out_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         free
);

  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (load)       valid_d = 1'b1;
    else if (ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

  assign free = !valid || ready;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));

  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && valid && !ready));

endmodule

// File: rtl/cmdp_seq.sv
module cmdp_seq
  import cmdp_pkg::*;
#(
  parameter logic [OPC_W-1:0]  SWAP_OPC = 7'h64,
  parameter int                SWAP_LEN = 4,
  parameter logic [WORD_W-1:0] SWAP_SIG = 32'h584E4558
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] word,
  input  hdr_t              hdr,
  output logic              rw_emit,
  output logic [IDX_W-1:0]  rw_idx,
  output logic              cmd_emit,
  output logic              cmd_first,
  output logic [CNT_W-1:0]  cmd_pos,
  output logic              last_word,
  output logic              sig_bad
);

  localparam logic [CNT_W-1:0] SWAP_M1 = CNT_W'(SWAP_LEN - 1);

  pstate_e           st_q,   st_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic [PAIR_W-1:0] idxb_q, idxb_d;
  logic [CNT_W-1:0]  pos_q,  pos_d;
  logic              hold_q, hold_d;
  logic              swap_q, swap_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    idxb_d    = idxb_q;
    pos_d     = pos_q;
    hold_d    = hold_q;
    swap_d    = swap_q;
    rw_emit   = 1'b0;
    rw_idx    = idx_q;
    cmd_emit  = 1'b0;
    cmd_first = 1'b0;
    cmd_pos   = pos_q;
    last_word = 1'b0;
    sig_bad   = 1'b0;
    if (fire) begin
      unique case (st_q)
        ST_HDR: begin
          unique case (hdr.kind)
            PK_RUN: begin
              st_d   = ST_RUN;
              cnt_d  = hdr.len_m1;
              idx_d  = hdr.base;
              hold_d = hdr.hold;
            end
            PK_PAIR: begin
              st_d   = ST_PR_A;
              idx_d  = IDX_W'(hdr.idx_a);
              idxb_d = hdr.idx_b;
            end
            PK_NOP: begin
              last_word = 1'b1;
            end
            PK_CMD: begin
              cmd_emit  = 1'b1;
              cmd_first = 1'b1;
              cmd_pos   = '0;
              st_d      = ST_PAY;
              cnt_d     = hdr.len_m1;
              pos_d     = '0;
              swap_d    = (hdr.opc == SWAP_OPC) && (hdr.len_m1 == SWAP_M1);
            end
            default: ;
          endcase
        end
        ST_RUN: begin
          rw_emit = 1'b1;
          if (!hold_q) idx_d = idx_q + 1'b1;
          if (cnt_q == '0) begin
            last_word = 1'b1;
            st_d      = ST_HDR;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_PR_A: begin
          rw_emit = 1'b1;
          st_d    = ST_PR_B;
        end
        ST_PR_B: begin
          rw_emit   = 1'b1;
          rw_idx    = IDX_W'(idxb_q);
          last_word = 1'b1;
          st_d      = ST_HDR;
        end
        ST_PAY: begin
          cmd_emit = 1'b1;
          pos_d    = pos_q + 1'b1;
          sig_bad  = swap_q && (pos_q == '0) && (word != SWAP_SIG);
          if (cnt_q == '0) begin
            last_word = 1'b1;
            st_d      = ST_HDR;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: st_d = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      cnt_q  <= '0;
      idx_q  <= '0;
      idxb_q <= '0;
      pos_q  <= '0;
      hold_q <= 1'b0;
      swap_q <= 1'b0;
    end else if (fire) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      idxb_q <= idxb_d;
      pos_q  <= pos_d;
      hold_q <= hold_d;
      swap_q <= swap_d;
    end
  end

  // R5
  nop_stays_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR && fire && hdr.kind == PK_NOP) |=> (st_q == ST_HDR));

  // R6
  cmd_enters_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR && fire && hdr.kind == PK_CMD) |=> (st_q == ST_PAY));

  // R9
  done_returns_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (st_q == ST_HDR));

  // R3
  hold_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && hold_q && fire) |=> (idx_q == $past(idx_q)));

endmodule

// File: rtl/cmdstream_parser.sv
module cmdstream_parser
  import cmdp_pkg::*;
#(
  parameter logic [6:0]  SWAP_OPC = 7'h64,
  parameter int          SWAP_LEN = 4,
  parameter logic [31:0] SWAP_SIG = 32'h584E4558
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        in_ready,
  output logic        rw_valid,
  input  logic        rw_ready,
  output logic [14:0] rw_index,
  output logic [31:0] rw_data,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic        cmd_start,
  output logic [6:0]  cmd_opcode,
  output logic [14:0] cmd_count,
  output logic        cmd_pred,
  output logic [13:0] cmd_pos,
  output logic [31:0] cmd_data,
  output logic        pkt_done,
  output logic        sig_err
);

  localparam int RW_W  = IDX_W + WORD_W;
  localparam int CMD_W = 1 + OPC_W + NUM_W + 1 + CNT_W + WORD_W;

  hdr_t              hdr;
  logic              fire;
  logic              rw_free, cmd_free;
  logic              rw_emit, cmd_emit, cmd_first;
  logic [IDX_W-1:0]  seq_idx;
  logic [CNT_W-1:0]  seq_pos;
  logic [NUM_W-1:0]  len_p1;
  logic [RW_W-1:0]   rw_din,  rw_dout;
  logic [CMD_W-1:0]  cmd_din, cmd_dout;

  assign in_ready = rw_free && cmd_free;
  assign fire     = in_valid && in_ready;

  cmdp_hdr_decode u_dec (
    .word (in_word),
    .hdr  (hdr)
  );

  cmdp_seq #(
    .SWAP_OPC (SWAP_OPC),
    .SWAP_LEN (SWAP_LEN),
    .SWAP_SIG (SWAP_SIG)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .word      (in_word),
    .hdr       (hdr),
    .rw_emit   (rw_emit),
    .rw_idx    (seq_idx),
    .cmd_emit  (cmd_emit),
    .cmd_first (cmd_first),
    .cmd_pos   (seq_pos),
    .last_word (pkt_done),
    .sig_bad   (sig_err)
  );

  assign len_p1 = NUM_W'(hdr.len_m1) + 1'b1;
  assign rw_din = {seq_idx, in_word};

  always_comb begin
    if (cmd_first)
      cmd_din = {1'b1, hdr.opc, len_p1, hdr.pred, {CNT_W{1'b0}}, in_word};
    else
      cmd_din = {1'b0, {OPC_W{1'b0}}, {NUM_W{1'b0}}, 1'b0, seq_pos, in_word};
  end

  cmdp_out_slot #(.W(RW_W)) u_rw_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rw_emit),
    .din   (rw_din),
    .ready (rw_ready),
    .valid (rw_valid),
    .dout  (rw_dout),
    .free  (rw_free)
  );

  cmdp_out_slot #(.W(CMD_W)) u_cmd_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_emit),
    .din   (cmd_din),
    .ready (cmd_ready),
    .valid (cmd_valid),
    .dout  (cmd_dout),
    .free  (cmd_free)
  );

  assign {rw_index, rw_data} = rw_dout;
  assign {cmd_start, cmd_opcode, cmd_count, cmd_pred, cmd_pos, cmd_data} = cmd_dout;

  // R10
  rw_stall_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_valid && !rw_ready) |-> !fire);

  // R8
  sig_err_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |-> (fire && !cmd_first && cmd_emit));

endmodule

// File: tb/cmdstream_parser_bench.sv
module cmdstream_parser_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_ready;
  logic        rw_valid, rw_ready;
  logic [14:0] rw_index;
  logic [31:0] rw_data;
  logic        cmd_valid, cmd_ready, cmd_start, cmd_pred;
  logic [6:0]  cmd_opcode;
  logic [14:0] cmd_count;
  logic [13:0] cmd_pos;
  logic [31:0] cmd_data;
  logic        pkt_done, sig_err;

  always #10 clk = ~clk;

  cmdstream_parser u_cmdstream_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .rw_valid(rw_valid), .rw_ready(rw_ready), .rw_index(rw_index), .rw_data(rw_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_start(cmd_start),
    .cmd_opcode(cmd_opcode), .cmd_count(cmd_count), .cmd_pred(cmd_pred),
    .cmd_pos(cmd_pos), .cmd_data(cmd_data), .pkt_done(pkt_done), .sig_err(sig_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] stim[$];
  logic [46:0] exp_rw[$];
  string       exp_rw_tag[$];
  logic [69:0] exp_cmd[$];
  string       exp_cmd_tag[$];

  int          ms = 0;
  int          mrem, mpos;
  logic [14:0] midx;
  logic [10:0] ma, mb;
  logic        mhold, mswap;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [69:0] act, input logic [69:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w, output bit done, output bit serr, output string dtag);
    done = 0; serr = 0; dtag = "R9";
    case (ms)
      0: begin
        case (w[31:30])
          2'd0: begin mrem = int'(w[29:16]) + 1; midx = w[14:0]; mhold = w[15]; ms = 1; end
          2'd1: begin ma = w[10:0]; mb = w[21:11]; ms = 2; end
          2'd2: begin done = 1; dtag = "R5"; end
          default: begin
            mrem = int'(w[29:16]) + 1;
            exp_cmd.push_back({1'b1, w[14:8], 15'(mrem), w[0], 14'd0, w});
            exp_cmd_tag.push_back("R2 R6");
            mpos = 0; mswap = (w[14:8] == 7'h64) && (mrem == 4); ms = 4;
          end
        endcase
      end
      1: begin
        exp_rw.push_back({midx, w}); exp_rw_tag.push_back("R2 R3");
        if (!mhold) midx = midx + 15'd1;
        mrem--; if (mrem == 0) begin done = 1; ms = 0; end
      end
      2: begin exp_rw.push_back({4'd0, ma, w}); exp_rw_tag.push_back("R4"); ms = 3; end
      3: begin exp_rw.push_back({4'd0, mb, w}); exp_rw_tag.push_back("R4"); done = 1; ms = 0; end
      default: begin
        exp_cmd.push_back({1'b0, 7'd0, 15'd0, 1'b0, 14'(mpos), w});
        exp_cmd_tag.push_back("R7");
        if (mpos == 0 && mswap && w != 32'h584E4558) serr = 1;
        mpos++; mrem--; if (mrem == 0) begin done = 1; ms = 0; end
      end
    endcase
  endtask

  task automatic add_run(input int base, input int n, input bit hold);
    stim.push_back({2'd0, 14'(n - 1), hold, 15'(base)});
    for (int i = 0; i < n; i++) stim.push_back($urandom);
  endtask

  task automatic add_pair(input int a, input int b);
    stim.push_back({2'd1, 8'hA5, 11'(b), 11'(a)});
    stim.push_back($urandom);
    stim.push_back($urandom);
  endtask

  task automatic add_cmd(input int opc, input int n, input bit pred, input logic [31:0] first);
    stim.push_back({2'd3, 14'(n - 1), 1'b0, 7'(opc), 7'h2A, pred});
    stim.push_back(first);
    for (int i = 1; i < n; i++) stim.push_back($urandom);
  endtask

  initial begin
    int ptr = 0;
    int cyc = 0;
    int vpct = 85;
    int rpct = 80;
    bit fire, edone, eserr;
    string dtag;

    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; rw_ready = 1'b0; cmd_ready = 1'b0;

    stim.push_back(32'h8000_0000);
    stim.push_back(32'hBFFF_FFFF);
    add_run(16'h0010, 6, 0);
    add_run(16'h0020, 3, 1);
    add_run(16'h7FFE, 4, 0);
    add_pair(11'h7FF, 11'h001);
    add_cmd(7'h22, 1, 1, $urandom);
    add_cmd(7'h64, 4, 0, 32'h584E4558);
    add_cmd(7'h64, 4, 1, 32'h12345678);
    add_cmd(7'h64, 5, 0, 32'h00000000);
    add_cmd(7'h10, 4, 0, 32'hDEADBEEF);
    add_run(0, 16384, 0);
    add_cmd(7'h3F, 16384, 1, $urandom);
    for (int p = 0; p < 80; p++) begin
      case ($urandom_range(0, 4))
        0: add_run($urandom_range(0, 32767), $urandom_range(1, 9), 1'($urandom_range(0, 1)));
        1: add_pair($urandom_range(0, 2047), $urandom_range(0, 2047));
        2: stim.push_back({2'd2, 30'($urandom)});
        3: add_cmd($urandom_range(0, 127), $urandom_range(1, 8), 1'($urandom_range(0, 1)), $urandom);
        default: add_cmd(7'h64, 4, 0, ($urandom_range(0, 1) != 0) ? 32'h584E4558 : $urandom);
      endcase
    end

    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rw_valid == 0, "R1", "rw_valid in reset", 70'(rw_valid), 70'd0);
    chk(cmd_valid == 0, "R1", "cmd_valid in reset", 70'(cmd_valid), 70'd0);
    chk(pkt_done == 0, "R1", "pkt_done in reset", 70'(pkt_done), 70'd0);
    chk(sig_err == 0, "R1", "sig_err in reset", 70'(sig_err), 70'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1, "R1", "in_ready after reset", 70'(in_ready), 70'd1);
    chk(rw_valid == 0 && cmd_valid == 0, "R1", "ports empty after reset",
        70'({rw_valid, cmd_valid}), 70'd0);

    forever begin
      if (ptr >= stim.size() && exp_rw.size() == 0 && exp_cmd.size() == 0 &&
          !rw_valid && !cmd_valid) break;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=%0d expected=<150000", cyc);
        break;
      end
      if (ptr > stim.size() / 2 && ptr < stim.size() / 2 + 40) rpct = 20;
      else rpct = 80;
      in_valid  = (ptr < stim.size()) && ($urandom_range(1, 100) <= vpct);
      in_word   = (ptr < stim.size()) ? stim[ptr] : 32'h0;
      rw_ready  = $urandom_range(1, 100) <= rpct;
      cmd_ready = $urandom_range(1, 100) <= rpct;
      #5;
      fire = in_valid && in_ready;
      if (rw_valid && !rw_ready)
        chk(!in_ready, "R10", "in_ready while rw stalled", 70'(in_ready), 70'd0);
      if (cmd_valid && !cmd_ready)
        chk(!in_ready, "R10", "in_ready while cmd stalled", 70'(in_ready), 70'd0);
      if (rw_valid && rw_ready) begin
        if (exp_rw.size() == 0)
          chk(0, "R10", "unexpected rw beat", 70'({rw_index, rw_data}), 70'd0);
        else begin
          logic [46:0] e;
          string t;
          e = exp_rw.pop_front(); t = exp_rw_tag.pop_front();
          chk({rw_index, rw_data} == e, t, "rw beat", 70'({rw_index, rw_data}), 70'(e));
        end
      end
      if (cmd_valid && cmd_ready) begin
        logic [69:0] a;
        a = {cmd_start, cmd_opcode, cmd_count, cmd_pred, cmd_pos, cmd_data};
        if (exp_cmd.size() == 0) chk(0, "R10", "unexpected cmd beat", a, 70'd0);
        else begin
          logic [69:0] e;
          string t;
          e = exp_cmd.pop_front(); t = exp_cmd_tag.pop_front();
          chk(a == e, t, "cmd beat", a, e);
        end
      end
      edone = 0; eserr = 0; dtag = "R9";
      if (fire) begin
        model(in_word, edone, eserr, dtag);
        ptr++;
      end
      chk(pkt_done == edone, dtag, "pkt_done", 70'(pkt_done), 70'(edone));
      chk(sig_err == eserr, "R8", "sig_err", 70'(sig_err), 70'(eserr));
      @(negedge clk);
      cyc++;
    end

    chk(exp_rw.size() == 0, "R10", "rw beats outstanding", 70'(exp_rw.size()), 70'd0);
    chk(exp_cmd.size() == 0, "R10", "cmd beats outstanding", 70'(exp_cmd.size()), 70'd0);
    chk(ms == 0, "R2", "stream ends on a header boundary", 70'(ms), 70'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule